// File: doc/BRIEF.md
# Reduced single-precision floating-point arithmetic unit

This unit takes two binary floating-point words and a 2-bit opcode, and returns one result word one clock later. The opcode selects one of four operations: sum, difference, product or ordering. Each operand is unpacked into a sign, a biased exponent and a fraction, and the hidden leading one is made explicit. Sums and differences align the operand with the smaller exponent by shifting it right. All arithmetic results then pass through one shared normaliser, which brings the leading one back to the top of the mantissa.

The datapath is deliberately reduced. Alignment and normalisation truncate, and there is no rounding. Special encodings such as infinities and NaNs get no special handling: every non-zero pattern is treated as a normal number. The ordering operation returns a 2-bit code in the low bits of an otherwise zero word. The exponent and fraction widths are parameters, so a narrow copy of the unit can be built for verification.

Top module: `fpu_core`

## Requirements
- R1: An operand whose exponent and fraction fields are both zero is zero and has a zero mantissa. Every other operand has mantissa {1, fraction}, including those with a zero exponent field. The word layout is sign in the MSB, then the exponent field biased by 2^(EXP_W-1)-1, then the fraction in the LSBs.
- R2: For a sum or difference, the result exponent starts at the larger of the two operand exponents. The other mantissa is shifted right by the exponent difference, and the bits shifted out are dropped.
- R3: With op_i = 00 (sum), equal signs add the mantissas and keep that sign. Unequal signs subtract the smaller mantissa from the larger, and the result takes the sign of the larger one.
- R4: With op_i = 01 (difference), the flow of R3 is used with the sign of b_i inverted. Mantissas are therefore added when the signs differ and subtracted when they are equal.
- R5: With op_i = 10 (product), the sign is the XOR of the operand signs and the exponent is ea + eb - bias. The mantissas are multiplied at full width, and the mantissa is taken from the top of the product.
- R6: A carry out of a mantissa sum, or a set top product bit, shifts the mantissa right by one and adds one to the exponent. Otherwise the mantissa is shifted left, one place per unit subtracted from the exponent, until its MSB is 1. The stored fraction is the mantissa without its leading one.
- R7: With op_i = 11 (ordering), the sign is examined first: the operand with a clear sign bit is greater. If the signs are equal, the larger exponent field is greater, then the larger fraction field. This holds for negative operands too, with no inversion of magnitude. Identical fields give equal.
- R8: The ordering result is 01 for a > b, 00 for equal and 10 for a < b. The code sits in res_o[1:0], all higher bits are 0, and 11 is never produced.
- R9: An arithmetic result whose mantissa is zero is output as the all-zero word (+0). This includes an exact cancellation and a product with a zero operand.
- R10: An exponent that leaves the field range keeps only its low EXP_W bits. There is no saturation and no flag.
- R11: res_o is 0 while rst_ni is low. A result appears on res_o after the first rising clk_i edge that samples its operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 sum, 01 difference, 10 product, 11 ordering |
| a_i | input | 1+EXP_W+FRAC_W | First operand |
| b_i | input | 1+EXP_W+FRAC_W | Second operand |
| res_o | output | 1+EXP_W+FRAC_W | Registered result, or ordering code in bits 1:0 |

## Verification
The bench builds the unit with EXP_W = 3 and FRAC_W = 2, which gives a 6-bit word. At that size every operand pair under every opcode can be applied, 16384 vectors in all, and each one is compared against an integer model of the stated rules. The sweep therefore reaches every alignment distance, including shifts past the whole mantissa. It also reaches every cancellation depth in the normaliser, carry outs, exponent wrap in both directions, and every sign and field tie in the ordering. Directed vectors are added first, so that zeros, truncation, wrap, negative ordering and the one-cycle latency are each named against their own requirement.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_CMP = 2'b11
  } fpu_op_e;

  localparam logic [1:0] ORD_GT = 2'b01;
  localparam logic [1:0] ORD_EQ = 2'b00;
  localparam logic [1:0] ORD_LT = 2'b10;
endpackage

// File: rtl/fpu_unpack.sv
module fpu_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W-1:0]     frac_o,
  output logic [FRAC_W:0]       mant_o
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic is_zero;

  assign sign_o  = word_i[W-1];
  assign exp_o   = word_i[W-2:FRAC_W];
  assign frac_o  = word_i[FRAC_W-1:0];
  assign is_zero = (exp_o == '0) && (frac_o == '0);
  // hidden one is explicit except for the zero encoding
  assign mant_o  = is_zero ? '0 : {1'b1, frac_o};
endmodule

// File: rtl/fpu_addsub.sv
module fpu_addsub #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int XW     = EXP_W + 3
) (
  input  logic                 sub_i,
  input  logic                 sa_i,
  input  logic [EXP_W-1:0]     ea_i,
  input  logic [FRAC_W:0]      ma_i,
  input  logic                 sb_i,
  input  logic [EXP_W-1:0]     eb_i,
  input  logic [FRAC_W:0]      mb_i,
  output logic                 sign_o,
  output logic signed [XW-1:0] exp_o,
  output logic [FRAC_W+1:0]    raw_o
);
  localparam int M = FRAC_W + 1;

  logic             sb_eff;
  logic [EXP_W-1:0] diff;
  logic [M-1:0]     ax, bx;

  assign sb_eff = sb_i ^ sub_i;

  // alignment: smaller exponent operand shifted right, truncating
  always_comb begin
    if (ea_i >= eb_i) begin
      diff  = ea_i - eb_i;
      exp_o = XW'(ea_i);
      ax    = ma_i;
      bx    = mb_i >> diff;
    end else begin
      diff  = eb_i - ea_i;
      exp_o = XW'(eb_i);
      ax    = ma_i >> diff;
      bx    = mb_i;
    end
  end

  always_comb begin
    if (sa_i == sb_eff) begin
      raw_o  = (M+1)'(ax) + (M+1)'(bx);
      sign_o = sa_i;
    end else if (ax > bx) begin
      raw_o  = {1'b0, ax - bx};
      sign_o = sa_i;
    end else begin
      raw_o  = {1'b0, bx - ax};
      sign_o = sb_eff;
    end
  end
endmodule

// File: rtl/fpu_mul.sv
module fpu_mul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int XW     = EXP_W + 3
) (
  input  logic                 sa_i,
  input  logic [EXP_W-1:0]     ea_i,
  input  logic [FRAC_W:0]      ma_i,
  input  logic                 sb_i,
  input  logic [EXP_W-1:0]     eb_i,
  input  logic [FRAC_W:0]      mb_i,
  output logic                 sign_o,
  output logic signed [XW-1:0] exp_o,
  output logic [FRAC_W+1:0]    raw_o
);
  localparam int M    = FRAC_W + 1;
  localparam int BIAS = 2 ** (EXP_W - 1) - 1;

  logic [2*M-1:0] prod;

  assign sign_o = sa_i ^ sb_i;
  assign prod   = (2*M)'(ma_i) * (2*M)'(mb_i);
  // top M+1 product bits; MSB acts as the carry position for the normaliser
  assign raw_o  = prod[2*M-1:M-1];
  assign exp_o  = XW'(ea_i) + XW'(eb_i) - XW'(BIAS);
endmodule

// File: rtl/fpu_norm.sv
module fpu_norm #(
  parameter int FRAC_W = 23,
  parameter int XW     = 11
) (
  input  logic [FRAC_W+1:0]    raw_i,
  input  logic signed [XW-1:0] exp_i,
  output logic [FRAC_W:0]      mant_o,
  output logic signed [XW-1:0] exp_o,
  output logic                 zero_o
);
  localparam int M = FRAC_W + 1;

  logic [XW-1:0] sh;

  // leading-one scan, highest set bit wins
  always_comb begin
    sh = '0;
    for (int i = 0; i < M; i++) begin
      if (raw_i[i]) sh = XW'(M - 1 - i);
    end
  end

  assign zero_o = (raw_i == '0);

  always_comb begin
    if (raw_i[M]) begin
      mant_o = raw_i[M:1];
      exp_o  = exp_i + XW'(1);
    end else begin
      mant_o = raw_i[M-1:0] << sh;
      exp_o  = exp_i - $signed(sh);
    end
  end
endmodule

// File: rtl/fpu_cmp.sv
module fpu_cmp
  import fpu_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              sa_i,
  input  logic [EXP_W-1:0]  ea_i,
  input  logic [FRAC_W-1:0] fa_i,
  input  logic              sb_i,
  input  logic [EXP_W-1:0]  eb_i,
  input  logic [FRAC_W-1:0] fb_i,
  output logic [1:0]        code_o
);
  // sign, then exponent field, then fraction field; no magnitude inversion
  always_comb begin
    if (sa_i != sb_i)     code_o = sa_i ? ORD_LT : ORD_GT;
    else if (ea_i > eb_i) code_o = ORD_GT;
    else if (eb_i > ea_i) code_o = ORD_LT;
    else if (fa_i > fb_i) code_o = ORD_GT;
    else if (fb_i > fa_i) code_o = ORD_LT;
    else                  code_o = ORD_EQ;
  end
endmodule

// File: rtl/fpu_core.sv
module fpu_core
  import fpu_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            op_i,
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  output logic [EXP_W+FRAC_W:0] res_o
);
  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int M  = FRAC_W + 1;
  localparam int XW = EXP_W + 3;

  fpu_op_e op;
  assign op = fpu_op_e'(op_i);

  logic [W-1:0]      opnd   [2];
  logic              s_u    [2];
  logic [EXP_W-1:0]  e_u    [2];
  logic [FRAC_W-1:0] f_u    [2];
  logic [M-1:0]      m_u    [2];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    fpu_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
      .word_i (opnd[g]),
      .sign_o (s_u[g]),
      .exp_o  (e_u[g]),
      .frac_o (f_u[g]),
      .mant_o (m_u[g])
    );
  end

  logic                 as_sign, mu_sign;
  logic signed [XW-1:0] as_exp, mu_exp;
  logic [M:0]           as_raw, mu_raw;

  fpu_addsub #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW)) u_addsub (
    .sub_i  (op == OP_SUB),
    .sa_i   (s_u[0]), .ea_i (e_u[0]), .ma_i (m_u[0]),
    .sb_i   (s_u[1]), .eb_i (e_u[1]), .mb_i (m_u[1]),
    .sign_o (as_sign),
    .exp_o  (as_exp),
    .raw_o  (as_raw)
  );

  fpu_mul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW)) u_mul (
    .sa_i   (s_u[0]), .ea_i (e_u[0]), .ma_i (m_u[0]),
    .sb_i   (s_u[1]), .eb_i (e_u[1]), .mb_i (m_u[1]),
    .sign_o (mu_sign),
    .exp_o  (mu_exp),
    .raw_o  (mu_raw)
  );

  // one normaliser shared by both arithmetic paths
  logic                 sel_mul;
  logic                 n_sign;
  logic signed [XW-1:0] n_exp_in, n_exp;
  logic [M:0]           n_raw;
  logic [M-1:0]         n_mant;
  logic                 n_zero;

  assign sel_mul  = (op == OP_MUL);
  assign n_sign   = sel_mul ? mu_sign : as_sign;
  assign n_exp_in = sel_mul ? mu_exp  : as_exp;
  assign n_raw    = sel_mul ? mu_raw  : as_raw;

  fpu_norm #(.FRAC_W(FRAC_W), .XW(XW)) u_norm (
    .raw_i  (n_raw),
    .exp_i  (n_exp_in),
    .mant_o (n_mant),
    .exp_o  (n_exp),
    .zero_o (n_zero)
  );

  logic [1:0] ord_code;

  fpu_cmp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cmp (
    .sa_i   (s_u[0]), .ea_i (e_u[0]), .fa_i (f_u[0]),
    .sb_i   (s_u[1]), .eb_i (e_u[1]), .fb_i (f_u[1]),
    .code_o (ord_code)
  );

  logic [W-1:0] res_d;

  always_comb begin
    if (op == OP_CMP)  res_d = {{(W-2){1'b0}}, ord_code};
    else if (n_zero)   res_d = '0;
    else               res_d = {n_sign, n_exp[EXP_W-1:0], n_mant[FRAC_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= res_d;
  end

  p_norm_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n_zero |-> n_mant[M-1]);

  p_cancel_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SUB && a_i == b_i) |=> (res_o == '0));

  p_mul_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MUL) |=> (res_o == '0 || res_o[W-1] == $past(a_i[W-1] ^ b_i[W-1])));

  p_cmp_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP && a_i[W-1] != b_i[W-1])
      |=> (res_o[1:0] == ($past(a_i[W-1]) ? ORD_LT : ORD_GT)));

  p_cmp_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |=> (res_o[W-1:2] == '0));

  p_cmp_no_code3_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |=> (res_o[1:0] != 2'b11));
endmodule

// File: tb/sim_fpu_core.sv
`timescale 1ns/1ps
module sim_fpu_core;
  localparam int EW = 3;
  localparam int FW = 2;
  localparam int W  = 1 + EW + FW;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [1:0]   op_i;
  logic [W-1:0] a_i, b_i;
  logic [W-1:0] res_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  fpu_core #(.EXP_W(EW), .FRAC_W(FW)) u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .op_i (op_i),
    .a_i (a_i), .b_i (b_i), .res_o (res_o)
  );

  // integer model of the requirements for the 6-bit format (bias 3, mantissa 3 bits)
  function automatic logic [W-1:0] model(int op, int a, int b);
    int sa, ea, fa, ma, sb, eb, fb, mb, s, e, m, r, p;
    sa = (a >> 5) & 1; ea = (a >> 2) & 7; fa = a & 3;
    sb = (b >> 5) & 1; eb = (b >> 2) & 7; fb = b & 3;
    ma = (ea == 0 && fa == 0) ? 0 : (4 | fa);
    mb = (eb == 0 && fb == 0) ? 0 : (4 | fb);
    if (op == 3) begin
      if (sa != sb)     return (sa == 1) ? 6'd2 : 6'd1;
      else if (ea > eb) return 6'd1;
      else if (eb > ea) return 6'd2;
      else if (fa > fb) return 6'd1;
      else if (fb > fa) return 6'd2;
      return 6'd0;
    end
    if (op == 2) begin
      p = ma * mb;
      if (p == 0) return 6'd0;
      s = sa ^ sb;
      e = ea + eb - 3;
      if (p >= 32) begin m = p >> 3; e = e + 1; end
      else m = p >> 2;
    end else begin
      if (op == 1) sb = sb ^ 1;
      if (ea >= eb) begin e = ea; mb = mb >> (ea - eb); end
      else begin e = eb; ma = ma >> (eb - ea); end
      if (sa == sb)     begin r = ma + mb; s = sa; end
      else if (ma > mb) begin r = ma - mb; s = sa; end
      else              begin r = mb - ma; s = sb; end
      if (r == 0) return 6'd0;
      if (r >= 8) begin m = r >> 1; e = e + 1; end
      else begin
        while (r < 4) begin r = r << 1; e = e - 1; end
        m = r;
      end
    end
    return W'((s << 5) | ((e & 7) << 2) | (m & 3));
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: op=%0d a=%h b=%h got=%h expected=%h", req, op_i, a_i, b_i, got, exp);
    end
  endtask

  task automatic apply(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b;
    @(posedge clk_i);
    #2;
  endtask

  task automatic vec(string req, logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b,
                     logic [W-1:0] exp);
    apply(op, a, b);
    check(req, res_o, exp);
  endtask

  initial begin
    rst_ni = 1'b0; op_i = 2'b00; a_i = 6'h0E; b_i = 6'h0E;
    repeat (3) @(posedge clk_i);
    #2 check("R11 reset", res_o, 6'h00);
    @(negedge clk_i) rst_ni = 1'b1;

    // R11: latency of one edge
    @(negedge clk_i);
    op_i = 2'b00; a_i = 6'h0C; b_i = 6'h0C;
    @(posedge clk_i); #2;
    @(negedge clk_i);
    op_i = 2'b10; a_i = 6'h0E; b_i = 6'h0E;
    #1 check("R11 hold", res_o, 6'h10);      // 1.0+1.0 = 2.0 still shown
    @(posedge clk_i); #2;
    check("R11 update", res_o, 6'h10);       // 1.5*1.5 truncates to 2.0

    vec("R1 x+0",        2'b00, 6'h0E, 6'h00, 6'h0E);
    vec("R1 0+0",        2'b00, 6'h00, 6'h00, 6'h00);
    vec("R1 subnormal",  2'b00, 6'h01, 6'h00, 6'h01);
    vec("R2 truncate",   2'b00, 6'h0C, 6'h07, 6'h0D);
    vec("R3 opp signs",  2'b00, 6'h2E, 6'h0D, 6'h24);
    vec("R4 sub",        2'b01, 6'h0E, 6'h2E, 6'h12);
    vec("R5 mul neg",    2'b10, 6'h2E, 6'h0C, 6'h2E);
    vec("R5 mul zero",   2'b10, 6'h1F, 6'h00, 6'h00);
    vec("R6 carry",      2'b00, 6'h0E, 6'h0E, 6'h12);
    vec("R6 left shift", 2'b01, 6'h0E, 6'h0D, 6'h04);
    vec("R9 cancel",     2'b01, 6'h0E, 6'h0E, 6'h00);
    vec("R9 neg cancel", 2'b00, 6'h2E, 6'h0E, 6'h00);
    vec("R10 add wrap",  2'b00, 6'h1F, 6'h1F, 6'h03);
    vec("R10 mul wrap",  2'b10, 6'h1F, 6'h1F, 6'h12);
    vec("R7 neg fields", 2'b11, 6'h2E, 6'h2C, 6'h01);
    vec("R7 signed zero",2'b11, 6'h00, 6'h20, 6'h01);
    vec("R8 gt",         2'b11, 6'h0E, 6'h0C, 6'h01);
    vec("R8 eq",         2'b11, 6'h0E, 6'h0E, 6'h00);
    vec("R8 lt",         2'b11, 6'h0C, 6'h0E, 6'h02);

    // exhaustive sweep
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 64; b++) begin
          apply(op[1:0], a[W-1:0], b[W-1:0]);
          case (op)
            0:       check("R3 sweep", res_o, model(op, a, b));
            1:       check("R4 sweep", res_o, model(op, a, b));
            2:       check("R5 sweep", res_o, model(op, a, b));
            default: check("R7 R8 sweep", res_o, model(op, a, b));
          endcase
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule